// File: doc/BRIEF.md
# Segment Override Address Generator

This block turns an instruction offset into a memory data address by adding the base of a chosen segment. It keeps six segment base registers: one for code, one for stack and four for data. Each instruction arrives as a stream of bytes. The stream may start with one or more override prefix bytes, followed by a single opcode byte. Together with the opcode byte, the instruction supplies its default segment class and its offset.

Each incoming byte is checked against the six override prefix codes. A prefix byte records a pending segment choice and produces no output. The opcode byte then uses the pending choice if there is one, and its own default class if there is not. The opcode byte clears the pending choice, so the next instruction starts from its default. The selected base plus the offset is registered and appears one cycle later, together with the segment index and a flag that tells whether a prefix was applied.

Software loads the bases through a simple write port. A write becomes visible to accesses that arrive in the following cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, out_valid is 0, every base register holds 0 and no override is pending. An access right after reset returns its offset as the address.
- R2: Segment indices are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. An opcode with no pending override uses in_dflt as its segment. in_dflt values 6 and 7 select DS.
- R3: The prefix bytes 0x26, 0x2E, 0x36, 0x3E, 0x64 and 0x65 select ES, CS, SS, DS, FS and GS. A prefix byte produces no output. Every other byte is an opcode.
- R4: When several prefix bytes come before one opcode, the last one received decides the segment.
- R5: An accepted opcode byte clears any pending override, so the next opcode uses its own default.
- R6: out_addr equals the selected base plus in_offset, taken modulo 2^ADDR_W.
- R7: A base write is seen by accesses in later cycles. An access in the same cycle as the write still uses the old base.
- R8: A write with wr_sel of 6 or 7 changes no base register.
- R9: out_valid is high for exactly one cycle, one cycle after each accepted opcode byte. Bytes presented while in_valid is low are ignored.
- R10: out_override is 1 when the output's segment came from a prefix, and 0 when it came from the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_byte carries an instruction byte this cycle |
| in_byte | input | 8 | Prefix or opcode byte |
| in_dflt | input | 3 | Default segment class of the opcode |
| in_offset | input | ADDR_W | Offset of the opcode's data access |
| wr_en | input | 1 | Write a segment base |
| wr_sel | input | 3 | Segment index to write |
| wr_base | input | ADDR_W | New base value |
| out_valid | output | 1 | Result valid |
| out_seg | output | 3 | Segment used |
| out_override | output | 1 | Segment came from a prefix |
| out_addr | output | ADDR_W | Base plus offset |

## Verification
Accesses are issued with no prefix for every default class, including the two unused class codes. This separates default selection from prefix decoding. Each of the six prefixes is sent alone before an opcode whose default is different, so that every prefix code is tied to its own segment. Chains of two and three prefixes show whether the first or the last prefix wins. A prefixed opcode followed by a plain one shows whether the override is cleared. A base near the top of the address range shows the wraparound. A write issued in the same cycle as an access, followed by a second access, shows exactly when a write takes effect. Writes to unused indices, and prefix bytes with in_valid low, must leave every later result unchanged.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int NUM_SEG = 6;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_e;

  function automatic logic is_prefix(input logic [7:0] b);
    return (b == 8'h26) || (b == 8'h2E) || (b == 8'h36) ||
           (b == 8'h3E) || (b == 8'h64) || (b == 8'h65);
  endfunction

  function automatic seg_e prefix_seg(input logic [7:0] b);
    case (b)
      8'h26:   return SEG_ES;
      8'h2E:   return SEG_CS;
      8'h36:   return SEG_SS;
      8'h64:   return SEG_FS;
      8'h65:   return SEG_GS;
      default: return SEG_DS;
    endcase
  endfunction

  function automatic seg_e resolve_default(input logic [SEL_W-1:0] c);
    if (c < SEL_W'(NUM_SEG)) return seg_e'(c);
    return SEG_DS;
  endfunction
endpackage

// File: rtl/seg_prefix_decode.sv
module seg_prefix_decode
  import seg_pkg::*;
(
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       pfx_hit,
  output logic       op_hit,
  output seg_e       pfx_seg
);
  logic byte_is_pfx;

  always_comb begin
    byte_is_pfx = is_prefix(in_byte);
    pfx_hit     = in_valid && byte_is_pfx;
    op_hit      = in_valid && !byte_is_pfx;
    pfx_seg     = prefix_seg(in_byte);
  end
endmodule

// File: rtl/seg_override_track.sv
module seg_override_track
  import seg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pfx_hit,
  input  logic op_hit,
  input  seg_e pfx_seg,
  output logic ovr_pend,
  output seg_e ovr_seg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_pend <= 1'b0;
      ovr_seg  <= SEG_DS;
    end else if (pfx_hit) begin
      ovr_pend <= 1'b1;
      ovr_seg  <= pfx_seg;
    end else if (op_hit) begin
      ovr_pend <= 1'b0;
    end
  end

  AST_PFX_LAST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_hit |=> (ovr_pend && ovr_seg == $past(pfx_seg))); // R4
  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    op_hit |=> !ovr_pend); // R5
endmodule

// File: rtl/seg_base_file.sv
module seg_base_file
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [ADDR_W-1:0]               wr_base,
  output logic [NUM_SEG-1:0][ADDR_W-1:0]  bases
);
  logic wr_legal;
  assign wr_legal = wr_en && (wr_sel < SEL_W'(NUM_SEG));

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_base
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bases[i] <= '0;
      else if (wr_legal && wr_sel == SEL_W'(i)) bases[i] <= wr_base;
    end
  end

  AST_BASE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_legal |=> bases[$past(wr_sel)] == $past(wr_base)); // R7
  AST_BAD_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_legal) |=> $stable(bases)); // R8
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic [2:0]        in_dflt,
  input  logic [ADDR_W-1:0] in_offset,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_base,
  output logic              out_valid,
  output logic [2:0]        out_seg,
  output logic              out_override,
  output logic [ADDR_W-1:0] out_addr
);
  function automatic logic [ADDR_W-1:0] addr_sum(input logic [ADDR_W-1:0] b,
                                                 input logic [ADDR_W-1:0] o);
    return b + o;
  endfunction

  logic                           pfx_hit;
  logic                           op_hit;
  seg_e                           pfx_seg;
  logic                           ovr_pend;
  seg_e                           ovr_seg;
  seg_e                           sel_seg;
  logic [NUM_SEG-1:0][ADDR_W-1:0] bases;
  logic [ADDR_W-1:0]              sel_base;
  logic [ADDR_W-1:0]              sum_addr;

  seg_prefix_decode u_dec (
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .pfx_hit  (pfx_hit),
    .op_hit   (op_hit),
    .pfx_seg  (pfx_seg)
  );

  seg_override_track u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pfx_hit  (pfx_hit),
    .op_hit   (op_hit),
    .pfx_seg  (pfx_seg),
    .ovr_pend (ovr_pend),
    .ovr_seg  (ovr_seg)
  );

  seg_base_file #(.ADDR_W(ADDR_W)) u_bases (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_base (wr_base),
    .bases   (bases)
  );

  always_comb begin
    sel_seg  = ovr_pend ? ovr_seg : resolve_default(in_dflt);
    sel_base = bases[sel_seg];
    sum_addr = addr_sum(sel_base, in_offset);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_seg      <= 3'd0;
      out_override <= 1'b0;
      out_addr     <= '0;
    end else begin
      out_valid <= op_hit;
      if (op_hit) begin
        out_seg      <= sel_seg;
        out_override <= ovr_pend;
        out_addr     <= sum_addr;
      end
    end
  end

  AST_SEG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_seg < 3'(NUM_SEG)); // R2
  AST_VALID_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    op_hit |=> out_valid); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !op_hit |=> !out_valid); // R9
  AST_DEFAULT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_hit && !ovr_pend) |=> !out_override); // R10
  AST_PREFIX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_hit && ovr_pend) |=> (out_override && out_seg == $past(ovr_seg))); // R3
endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  typedef struct packed {
    logic [2:0]    seg;
    logic          ovr;
    logic [AW-1:0] addr;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = 8'h00;
  logic [2:0]    in_dflt = 3'd0;
  logic [AW-1:0] in_offset = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = 3'd0;
  logic [AW-1:0] wr_base = '0;
  logic          out_valid;
  logic [2:0]    out_seg;
  logic          out_override;
  logic [AW-1:0] out_addr;

  int checks = 0;
  int errors = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  logic [AW-1:0] m_base [6];
  logic          m_pend;
  logic [2:0]    m_seg;
  bit            done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen #(.ADDR_W(AW)) u_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_dflt(in_dflt), .in_offset(in_offset), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_base(wr_base), .out_valid(out_valid), .out_seg(out_seg),
    .out_override(out_override), .out_addr(out_addr)
  );

  function automatic int pfx_code(input logic [7:0] b);
    case (b)
      8'h26: return 0;
      8'h2E: return 1;
      8'h36: return 2;
      8'h3E: return 3;
      8'h64: return 4;
      8'h65: return 5;
      default: return -1;
    endcase
  endfunction

  // One cycle of stimulus, starting and ending at a falling edge.
  task automatic drive(input bit v, input logic [7:0] b, input logic [2:0] d,
                       input logic [AW-1:0] off, input bit we, input logic [2:0] ws,
                       input logic [AW-1:0] wd, input string tag);
    exp_t e;
    int pc;
    pc = pfx_code(b);
    if (v && pc >= 0) begin
      m_pend = 1'b1;
      m_seg  = 3'(pc);
    end else if (v) begin
      e.ovr  = m_pend;
      e.seg  = m_pend ? m_seg : ((d > 3'd5) ? 3'd3 : d);
      e.addr = m_base[e.seg] + off;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      m_pend = 1'b0;
    end
    if (we && ws < 3'd6) m_base[ws] = wd;
    in_valid = v; in_byte = b; in_dflt = d; in_offset = off;
    wr_en = we; wr_sel = ws; wr_base = wd;
    @(negedge clk);
    in_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic op(input logic [7:0] b, input logic [2:0] d,
                    input logic [AW-1:0] off, input string tag);
    drive(1'b1, b, d, off, 1'b0, 3'd0, '0, tag);
  endtask

  task automatic wr(input logic [2:0] s, input logic [AW-1:0] v);
    drive(1'b0, 8'h00, 3'd0, '0, 1'b1, s, v, "R7");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 3'd0, '0, 1'b0, 3'd0, '0, "");
  endtask

  // Monitor: compare each output against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9: unexpected output seg=%0d addr=%h, expected none", out_seg, out_addr);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_seg !== e.seg || out_addr !== e.addr || out_override !== e.ovr) begin
          errors++;
          $display("FAIL %s: got seg=%0d ovr=%0d addr=%h, expected seg=%0d ovr=%0d addr=%h",
                   t, out_seg, out_override, out_addr, e.seg, e.ovr, e.addr);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) m_base[i] = '0;
    m_pend = 1'b0;
    m_seg  = 3'd0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_valid=%0d during reset, expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_valid=%0d after reset, expected 0", out_valid);
    end
    // R1: zero bases after reset
    op(8'h8B, 3'd3, 32'h0000_1234, "R1");
    op(8'h8B, 3'd5, 32'h0000_00AB, "R1");
    // R6 / R3: the two-base example
    wr(3'd3, 32'h0000_0500);
    wr(3'd0, 32'h0000_3500);
    op(8'h89, 3'd3, 32'h10, "R6");
    op(8'h26, 3'd3, '0, "R3");
    op(8'h89, 3'd3, 32'h10, "R3");
    // distinct bases for all six
    for (int i = 0; i < 6; i++) wr(3'(i), 32'h1000_0000 * (i + 1) + 32'h100);
    // R2: every default class, including 6 and 7
    for (int d = 0; d < 8; d++) op(8'h8B, 3'(d), 32'h20 + d, "R2");
    // R3: each prefix alone, default GS or ES so it differs
    begin
      logic [7:0] pf [6] = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65};
      for (int i = 0; i < 6; i++) begin
        op(pf[i], 3'd0, '0, "R3");
        op(8'hA1, (i == 5) ? 3'd0 : 3'd5, 32'h40 + i, "R3");
      end
    end
    // R4: chains
    op(8'h26, 3'd0, '0, "R4");
    op(8'h64, 3'd0, '0, "R4");
    op(8'h65, 3'd0, '0, "R4");
    op(8'h8B, 3'd3, 32'h7, "R4");
    op(8'h65, 3'd0, '0, "R4");
    op(8'h36, 3'd0, '0, "R4");
    op(8'h8B, 3'd3, 32'h8, "R4");
    // R5: override cleared for the next opcode
    op(8'h2E, 3'd0, '0, "R5");
    op(8'h8B, 3'd2, 32'h9, "R5");
    op(8'h8B, 3'd2, 32'hA, "R5");
    // R10: flag follows prefix vs default back to back
    op(8'h3E, 3'd0, '0, "R10");
    op(8'h8B, 3'd3, 32'hB, "R10");
    op(8'h8B, 3'd3, 32'hC, "R10");
    // R6: wraparound
    wr(3'd4, 32'hFFFF_FFF0);
    op(8'h64, 3'd0, '0, "R6");
    op(8'h8B, 3'd3, 32'h20, "R6");
    // R7: write and access in the same cycle
    drive(1'b1, 8'h8B, 3'd1, 32'h5, 1'b1, 3'd1, 32'h0ABC_0000, "R7");
    op(8'h8B, 3'd1, 32'h5, "R7");
    // R8: illegal write indices
    wr(3'd6, 32'hDEAD_BEEF);
    wr(3'd7, 32'hCAFE_F00D);
    for (int i = 0; i < 6; i++) op(8'h8B, 3'(i), 32'h1, "R8");
    // R9: prefix with in_valid low is ignored
    drive(1'b0, 8'h26, 3'd0, '0, 1'b0, 3'd0, '0, "R9");
    drive(1'b0, 8'h8B, 3'd3, 32'h3, 1'b0, 3'd0, '0, "R9");
    op(8'h8B, 3'd3, 32'h3, "R9");
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d results missing, expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule